// File: doc/BRIEF.md
# Conversion Result Holding Registers with Atomic Read Interlock

This block sits between a data converter's conversion engine and a CPU bus. When the engine signals that a conversion is done, the block captures the 10-bit result into a pair of byte-wide registers. A configuration input selects how the result is placed across the two bytes. In right-justified form the value starts at bit 0 of the low byte. In left-justified form the eight most significant bits fill the high byte, so software that needs only 8 bits can read a single register.

To keep a two-byte read coherent, the block implements a read interlock. A bus read of the low byte freezes both holding registers. A later read of the high byte releases them. A conversion that finishes while the registers are frozen is dropped. Its completion flag is still raised, so software can detect that a result went by.

The completion flag drives the interrupt output. It is cleared by a write-one-to-clear on the bus or by an acknowledge pulse. Reads are single-cycle: the read data is a combinational view of the addressed register during the read-strobe cycle.

Top module: `adc_result_interlock`

## Requirements
- R1: After reset, both holding registers read 0x00, the completion flag is 0 and the registers are not frozen.
- R2: The bus map is: address 0 is the low byte, address 1 is the high byte, and address 2 is the flag register with the flag in bit 0 and zeros above it. With justify-select low, a stored result D reads back as low = D[7:0] and high = {6'b0, D[9:8]}.
- R3: With justify-select high, a stored result D reads back as high = D[9:2] and low = {D[1:0], 6'b0}.
- R4: A read of address 0 freezes both holding registers from the following cycle. Completions while frozen leave both registers unchanged.
- R5: A read of address 1 releases the freeze. A completion in the same cycle as that high-byte read is stored, and that read returns the previous high byte.
- R6: Every completion strobe sets the flag on the next cycle, including completions whose result is discarded.
- R7: A read of address 1 while not frozen leaves the registers unfrozen, so later completions are stored. Only a low-byte read takes the freeze.
- R8: Changing justify-select does not alter data already held. It affects only the next stored result.
- R9: The flag is cleared by a write to address 2 with bit 0 set, or by the acknowledge input. A write with bit 0 clear has no effect. A completion in the same cycle as a clear leaves the flag set.
- R10: A completion in the same cycle as a low-byte read is discarded, and that read returns the previously held low byte.
- R11: The read data shows the addressed register in the same cycle as the read strobe. Reading address 2 neither takes nor releases the freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done_i | input | 1 | One-cycle strobe from the conversion engine |
| conv_data_i | input | 10 | Conversion result, valid with the strobe |
| left_adj_i | input | 1 | Justify select: 1 places the result left-justified |
| bus_rd_i | input | 1 | Single-cycle read strobe |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_addr_i | input | 2 | Register select |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the selected register |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| irq_o | output | 1 | Completion flag / interrupt request |

## Verification
The result path is driven with bit patterns whose top two bits and low bits differ, such as 0x2A5, 0x155 and 0x3C0. A misplaced shift or byte swap in either justification therefore shows up as a wrong byte value. Completions are placed before a low-byte read, between a low and a high read, in the same cycle as each read, and after a high-only read. These placements separate a missing freeze, a freeze that never releases, and a freeze that a high-only read wrongly takes. The flag is checked after kept and discarded completions, and against each clear path with and without a completion in the same cycle, so that set-over-clear priority is tested.

// File: rtl/adc_ril_pkg.sv
package adc_ril_pkg;

   typedef enum logic {
      LK_OPEN = 1'b0,
      LK_HELD = 1'b1
   } lock_e;

   localparam int unsigned DEF_RES_W  = 10;
   localparam int unsigned DEF_BYTE_W = 8;
   localparam int unsigned DEF_ADDR_W = 2;

endpackage

// File: rtl/adc_ril_formatter.sv
module adc_ril_formatter #(
   parameter int unsigned RES_W  = adc_ril_pkg::DEF_RES_W,
   parameter int unsigned BYTE_W = adc_ril_pkg::DEF_BYTE_W
) (
   input  logic [RES_W-1:0]  data_i,
   input  logic              left_i,
   output logic [BYTE_W-1:0] lo_o,
   output logic [BYTE_W-1:0] hi_o
);
   localparam int unsigned PAIR_W = 2 * BYTE_W;
   localparam int unsigned PAD_W  = PAIR_W - RES_W;

   logic [PAIR_W-1:0] right_w;
   logic [PAIR_W-1:0] left_w;
   logic [PAIR_W-1:0] word_w;

   generate
      if (PAD_W == 0) begin : g_nopad
         assign right_w = data_i;
         assign left_w  = data_i;
      end else begin : g_pad
         assign right_w = {{PAD_W{1'b0}}, data_i};
         assign left_w  = {data_i, {PAD_W{1'b0}}};
      end
   endgenerate

   assign word_w = left_i ? left_w : right_w;
   assign lo_o   = word_w[BYTE_W-1:0];
   assign hi_o   = word_w[PAIR_W-1:BYTE_W];

endmodule

// File: rtl/adc_ril_lock.sv
module adc_ril_lock
   import adc_ril_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic lo_rd_i,
   input  logic hi_rd_i,
   input  logic done_i,
   output logic held_o,
   output logic store_o
);
   lock_e state_q;
   lock_e state_d;

   always_comb begin
      state_d = state_q;
      if (lo_rd_i) begin
         state_d = LK_HELD;
      end else if (hi_rd_i) begin
         state_d = LK_OPEN;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LK_OPEN;
      end else begin
         state_q <= state_d;
      end
   end

   // A low read in the same cycle blocks the store; a high read releases it.
   assign store_o = done_i && !lo_rd_i && ((state_q == LK_OPEN) || hi_rd_i);
   assign held_o  = (state_q == LK_HELD);

endmodule

// File: rtl/adc_ril_store.sv
module adc_ril_store #(
   parameter int unsigned BYTE_W = adc_ril_pkg::DEF_BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [BYTE_W-1:0] lo_d,
   input  logic [BYTE_W-1:0] hi_d,
   output logic [BYTE_W-1:0] lo_q,
   output logic [BYTE_W-1:0] hi_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (we_i) begin
         lo_q <= lo_d;
         hi_q <= hi_d;
      end
   end
endmodule

// File: rtl/adc_ril_flag.sv
module adc_ril_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
      end else if (set_i) begin
         flag_o <= 1'b1;
      end else if (clr_i) begin
         flag_o <= 1'b0;
      end
   end
endmodule

// File: rtl/adc_result_interlock.sv
module adc_result_interlock #(
   parameter int unsigned RES_W     = adc_ril_pkg::DEF_RES_W,
   parameter int unsigned BYTE_W    = adc_ril_pkg::DEF_BYTE_W,
   parameter int unsigned ADDR_W    = adc_ril_pkg::DEF_ADDR_W,
   parameter int unsigned LO_ADDR   = 0,
   parameter int unsigned HI_ADDR   = 1,
   parameter int unsigned FLAG_ADDR = 2,
   parameter int unsigned FLAG_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_done_i,
   input  logic [RES_W-1:0]  conv_data_i,
   input  logic              left_adj_i,
   input  logic              bus_rd_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [BYTE_W-1:0] bus_wdata_i,
   output logic [BYTE_W-1:0] bus_rdata_o,
   input  logic              irq_ack_i,
   output logic              irq_o
);
   localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(LO_ADDR);
   localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(HI_ADDR);
   localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);

   generate
      if (RES_W <= BYTE_W || RES_W > 2 * BYTE_W) begin : g_bad_width
         $error("RES_W must exceed BYTE_W and fit in two bytes");
      end
      if (LO_ADDR == HI_ADDR || LO_ADDR == FLAG_ADDR || HI_ADDR == FLAG_ADDR) begin : g_bad_map
         $error("register addresses must be distinct");
      end
      if (LO_ADDR >= (1 << ADDR_W) || HI_ADDR >= (1 << ADDR_W) ||
          FLAG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("register address exceeds ADDR_W");
      end
      if (FLAG_BIT >= BYTE_W) begin : g_bad_bit
         $error("FLAG_BIT outside the data byte");
      end
   endgenerate

   logic              lo_rd;
   logic              hi_rd;
   logic              w1c_clr;
   logic              locked;
   logic              store;
   logic [BYTE_W-1:0] lo_fmt;
   logic [BYTE_W-1:0] hi_fmt;
   logic [BYTE_W-1:0] lo_q;
   logic [BYTE_W-1:0] hi_q;
   logic              flag_q;
   logic              unused_wdata;

   assign lo_rd        = bus_rd_i && (bus_addr_i == A_LO);
   assign hi_rd        = bus_rd_i && (bus_addr_i == A_HI);
   assign w1c_clr      = bus_wr_i && (bus_addr_i == A_FLAG) && bus_wdata_i[FLAG_BIT];
   assign unused_wdata = ^bus_wdata_i;

   adc_ril_formatter #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
      .data_i (conv_data_i),
      .left_i (left_adj_i),
      .lo_o   (lo_fmt),
      .hi_o   (hi_fmt)
   );

   adc_ril_lock u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .lo_rd_i (lo_rd),
      .hi_rd_i (hi_rd),
      .done_i  (conv_done_i),
      .held_o  (locked),
      .store_o (store)
   );

   adc_ril_store #(.BYTE_W(BYTE_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (store),
      .lo_d  (lo_fmt),
      .hi_d  (hi_fmt),
      .lo_q  (lo_q),
      .hi_q  (hi_q)
   );

   adc_ril_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (conv_done_i),
      .clr_i  (w1c_clr || irq_ack_i),
      .flag_o (flag_q)
   );

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == A_LO) begin
         bus_rdata_o = lo_q;
      end else if (bus_addr_i == A_HI) begin
         bus_rdata_o = hi_q;
      end else if (bus_addr_i == A_FLAG) begin
         bus_rdata_o[FLAG_BIT] = flag_q;
      end
   end

   assign irq_o = flag_q;

endmodule

// File: rtl/adc_ril_checker.sv
module adc_ril_checker #(
   parameter int unsigned RES_W  = 10,
   parameter int unsigned BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              conv_done_i,
   input logic [RES_W-1:0]  conv_data_i,
   input logic              left_adj_i,
   input logic              lo_rd,
   input logic              hi_rd,
   input logic              w1c_clr,
   input logic              irq_ack_i,
   input logic              locked,
   input logic [BYTE_W-1:0] lo_q,
   input logic [BYTE_W-1:0] hi_q,
   input logic              irq_o
);
   localparam int unsigned PAIR_W = 2 * BYTE_W;
   localparam int unsigned PAD_W  = PAIR_W - RES_W;

   logic [PAIR_W-1:0] pair;
   logic [PAIR_W-1:0] exp_right;
   logic [PAIR_W-1:0] exp_left;
   logic              takes;

   assign pair      = {hi_q, lo_q};
   assign exp_right = PAIR_W'(conv_data_i);
   assign exp_left  = exp_right << PAD_W;
   assign takes     = conv_done_i && !lo_rd && (!locked || hi_rd);

   // R2
   a_r2_right_layout: assert property (@(posedge clk) disable iff (!rst_n)
      (takes && !left_adj_i) |=> pair == $past(exp_right));

   // R3
   a_r3_left_layout: assert property (@(posedge clk) disable iff (!rst_n)
      (takes && left_adj_i) |=> pair == $past(exp_left));

   // R4
   a_r4_lock_taken: assert property (@(posedge clk) disable iff (!rst_n)
      lo_rd |=> locked);

   // R4
   a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !hi_rd) |=> ($stable(lo_q) && $stable(hi_q)));

   // R5
   a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
      hi_rd |=> !locked);

   // R6
   a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done_i |=> irq_o);

   // R9
   a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ((w1c_clr || irq_ack_i) && !conv_done_i) |=> !irq_o);

   // R10
   a_r10_low_read_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done_i && lo_rd) |=> $stable(pair));

endmodule

bind adc_result_interlock adc_ril_checker #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .conv_done_i (conv_done_i),
   .conv_data_i (conv_data_i),
   .left_adj_i  (left_adj_i),
   .lo_rd       (lo_rd),
   .hi_rd       (hi_rd),
   .w1c_clr     (w1c_clr),
   .irq_ack_i   (irq_ack_i),
   .locked      (locked),
   .lo_q        (lo_q),
   .hi_q        (hi_q),
   .irq_o       (irq_o)
);

// File: tb/adc_result_interlock_bench.sv
module adc_result_interlock_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       conv_done_i = 1'b0;
   logic [9:0] conv_data_i = '0;
   logic       left_adj_i = 1'b0;
   logic       bus_rd_i = 1'b0;
   logic       bus_wr_i = 1'b0;
   logic [1:0] bus_addr_i = '0;
   logic [7:0] bus_wdata_i = '0;
   logic [7:0] bus_rdata_o;
   logic       irq_ack_i = 1'b0;
   logic       irq_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   adc_result_interlock u_adc_result_interlock (
      .clk         (clk),
      .rst_n       (rst_n),
      .conv_done_i (conv_done_i),
      .conv_data_i (conv_data_i),
      .left_adj_i  (left_adj_i),
      .bus_rd_i    (bus_rd_i),
      .bus_wr_i    (bus_wr_i),
      .bus_addr_i  (bus_addr_i),
      .bus_wdata_i (bus_wdata_i),
      .bus_rdata_o (bus_rdata_o),
      .irq_ack_i   (irq_ack_i),
      .irq_o       (irq_o)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
      end
   endtask

   // One bus/engine cycle: drive at negedge, sample read data, release after the edge.
   task automatic cyc(input logic done, input logic [9:0] d, input logic rd,
                      input logic [1:0] a, input logic wr, input logic [7:0] wd,
                      input logic ack, output logic [7:0] rdat);
      @(negedge clk);
      conv_done_i = done; conv_data_i = d;
      bus_rd_i = rd; bus_addr_i = a; bus_wr_i = wr; bus_wdata_i = wd;
      irq_ack_i = ack;
      #2 rdat = bus_rdata_o;
      @(posedge clk);
      #1;
      conv_done_i = 1'b0; bus_rd_i = 1'b0; bus_wr_i = 1'b0; irq_ack_i = 1'b0;
   endtask

   task automatic conv(input logic [9:0] d);
      logic [7:0] r;
      cyc(1'b1, d, 1'b0, 2'd0, 1'b0, 8'h00, 1'b0, r);
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] r);
      cyc(1'b0, '0, 1'b1, a, 1'b0, 8'h00, 1'b0, r);
   endtask

   task automatic wr_flag(input logic [7:0] wd);
      logic [7:0] r;
      cyc(1'b0, '0, 1'b0, 2'd2, 1'b1, wd, 1'b0, r);
   endtask

   task automatic chk_pair(input string tag, input logic [7:0] elo, input logic [7:0] ehi);
      logic [7:0] r;
      rd(2'd0, r); chk({tag, " low"}, r, elo);
      rd(2'd1, r); chk({tag, " high"}, r, ehi);
   endtask

   task automatic chk_flag(input string tag, input logic exp);
      logic [7:0] r;
      rd(2'd2, r);
      chk({tag, " flag reg"}, r, {7'b0, exp});
      chk({tag, " irq_o"}, {7'b0, irq_o}, {7'b0, exp});
   endtask

   task automatic t_reset;
      chk_flag("R1 reset", 1'b0);
      chk_pair("R1 reset", 8'h00, 8'h00);
      conv(10'h155);
      chk_pair("R1 unlocked after reset", 8'h55, 8'h01);
      wr_flag(8'h01);
   endtask

   task automatic t_right;
      left_adj_i = 1'b0;
      conv(10'h2A5);
      chk_flag("R6 set", 1'b1);
      chk_pair("R2 right", 8'hA5, 8'h02);
      wr_flag(8'h01);
      chk_flag("R9 w1c", 1'b0);
   endtask

   task automatic t_left;
      left_adj_i = 1'b1;
      conv(10'h2A5);
      chk_pair("R3 left", 8'h40, 8'hA9);
      wr_flag(8'h01);
   endtask

   task automatic t_justify_change;
      left_adj_i = 1'b0;
      chk_pair("R8 held data kept", 8'h40, 8'hA9);
   endtask

   task automatic t_lock;
      logic [7:0] r;
      left_adj_i = 1'b0;
      conv(10'h155);
      wr_flag(8'h01);
      rd(2'd0, r); chk("R4 low read", r, 8'h55);
      conv(10'h3FF);
      chk_flag("R6 discarded still flags R11 no unlock", 1'b1);
      rd(2'd1, r); chk("R4 frozen high", r, 8'h01);
      chk_pair("R4 frozen pair", 8'h55, 8'h01);
      conv(10'h0F0);
      chk_pair("R5 stored after release", 8'hF0, 8'h00);
      wr_flag(8'h01);
   endtask

   task automatic t_hi_same_cycle;
      logic [7:0] r;
      left_adj_i = 1'b0;
      rd(2'd0, r); chk("R5 prep low", r, 8'hF0);
      cyc(1'b1, 10'h2C3, 1'b1, 2'd1, 1'b0, 8'h00, 1'b0, r);
      chk("R5 same-cycle high read old", r, 8'h00);
      chk_pair("R5 same-cycle stored", 8'hC3, 8'h02);
      wr_flag(8'h01);
   endtask

   task automatic t_lo_same_cycle;
      logic [7:0] r;
      left_adj_i = 1'b0;
      conv(10'h111);
      wr_flag(8'h01);
      cyc(1'b1, 10'h222, 1'b1, 2'd0, 1'b0, 8'h00, 1'b0, r);
      chk("R10 low read old value", r, 8'h11);
      chk_flag("R10 R6 flag", 1'b1);
      rd(2'd1, r); chk("R10 high after", r, 8'h01);
      chk_pair("R10 discarded", 8'h11, 8'h01);
      wr_flag(8'h01);
   endtask

   task automatic t_left_hi_only;
      logic [7:0] r;
      left_adj_i = 1'b1;
      conv(10'h3C0);
      rd(2'd1, r); chk("R7 high only", r, 8'hF0);
      conv(10'h001);
      rd(2'd1, r); chk("R7 not locked by high read", r, 8'h00);
      chk_pair("R7 pair", 8'h40, 8'h00);
      wr_flag(8'h01);
      left_adj_i = 1'b0;
   endtask

   task automatic t_flag;
      logic [7:0] r;
      conv(10'h005);
      cyc(1'b0, '0, 1'b0, 2'd0, 1'b0, 8'h00, 1'b1, r);
      chk_flag("R9 ack clears", 1'b0);
      conv(10'h006);
      wr_flag(8'hFE);
      chk_flag("R9 bit0 clear no effect", 1'b1);
      cyc(1'b1, 10'h007, 1'b0, 2'd0, 1'b0, 8'h00, 1'b1, r);
      chk_flag("R9 set wins over ack", 1'b1);
      cyc(1'b1, 10'h008, 1'b0, 2'd2, 1'b1, 8'h01, 1'b0, r);
      chk_flag("R9 set wins over w1c", 1'b1);
      chk_pair("R9 R2 last stored", 8'h08, 8'h00);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_right();
      t_left();
      t_justify_change();
      t_lock();
      t_hi_same_cycle();
      t_lo_same_cycle();
      t_left_hi_only();
      t_flag();
      repeat (2) @(posedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule